// File: doc/BRIEF.md
# Odd-Even Transposition Sorter

This block sorts a fixed set of N unsigned values held in a register array. A caller presents all N values at once on a parallel input together with a one-cycle start pulse. The block then runs N compare-exchange phases, one per clock. Each phase compares neighbouring elements and places the smaller value at the lower index.

The neighbour pairing alternates from one phase to the next. The first phase pairs each even index with the index above it. The second phase pairs each odd index with the index above it and leaves both end elements untouched. The array is visible on a parallel output at all times. After the last phase the block pulses a done flag, and the output holds the values in ascending order until the next accepted start.

The block always runs the full N phases and does not stop early when a pass makes no swaps. This fixes the latency at N cycles for every input.

Top module: `oet_sorter`

## Requirements
- R1: After reset, busy and done are 0 and every element of the sorted output is 0.
- R2: A start pulse while busy is 0 loads all N elements from load_data into the array. Element k occupies bits [k*W +: W]. In the following cycle busy is 1 and the output equals load_data.
- R3: On phases 1, 3, 5, ... (counted from 1 after the load) the pairs of 0-based indices (0,1), (2,3), ..., (N-2,N-1) are compare-exchanged at the same edge. The lower index receives the unsigned minimum and the higher index the maximum. With N=8 and input elements 3,2,3,8,5,6,4,1 (index 0 first), the output after phase 1 is 2,3,3,8,5,6,1,4.
- R4: On phases 2, 4, 6, ... the pairs (1,2), (3,4), ..., (N-3,N-2) are compare-exchanged in the same way. Elements 0 and N-1 are unchanged.
- R5: Exactly N phases run after each accepted start, and busy stays 1 for exactly N cycles.
- R6: Done is high for exactly one cycle, N cycles after the cycle in which start was accepted. Busy is 0 in that cycle.
- R7: When done is high, the output holds the loaded values in ascending unsigned order, for any input pattern including repeated values and the extremes 0 and 2^W-1.
- R8: A start pulse while busy is 1 is ignored. Neither the load data nor the phase count is affected.
- R9: While busy is 0 and no start is given, the output holds its value.
- R10: An odd N, or an N below 2, stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to load and sort |
| load_data | input | N*W | Values to sort, element k at bits [k*W +: W] |
| sorted | output | N*W | Current array contents, same layout |
| busy | output | 1 | High while phases are running |
| done | output | 1 | One-cycle pulse when the sort completes |

## Verification
The bench runs several input patterns:
- A mixed example. Its first-phase result separates the two pairings and shows which index gets the minimum.
- A strictly descending set. This is the worst case: it needs every one of the N phases, so a short phase count or a wrong alternation order leaves it unsorted.
- An already ascending set and an all-equal set. These catch a comparator that swaps on equality or on the wrong side.
- Sets that include 0 and the top code. These expose a signed or truncated compare.
- Random sets.

A start pulse during a run checks that the run cannot be restarted. Idle cycles after done check that the result holds.

// File: rtl/oet_pkg.sv
package oet_pkg;

  // Neighbour pairing used in a phase
  typedef enum logic {
    PAIR_LOW  = 1'b0,   // pairs (0,1),(2,3),...
    PAIR_HIGH = 1'b1    // pairs (1,2),(3,4),...; ends pass through
  } pairing_e;

  function automatic pairing_e pairing_of(input logic phase_lsb);
    return phase_lsb ? PAIR_HIGH : PAIR_LOW;
  endfunction

endpackage

// File: rtl/oet_cmp_xchg.sv
module oet_cmp_xchg #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] out_lo,
  output logic [W-1:0] out_hi
);

  logic swap;

  always_comb begin
    swap   = (in_a > in_b);
    out_lo = swap ? in_b : in_a;
    out_hi = swap ? in_a : in_b;
  end

endmodule

// File: rtl/oet_net.sv
module oet_net
  import oet_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N*W-1:0] cur,
  input  pairing_e       pairing,
  output logic [N*W-1:0] nxt
);

  localparam int NLOW  = N / 2;
  localparam int NHIGH = N / 2 - 1;

  logic [N*W-1:0] res_low;
  logic [N*W-1:0] res_high;

  // Pairing starting at index 0
  for (genvar i = 0; i < NLOW; i++) begin : g_low
    oet_cmp_xchg #(.W(W)) u_cx (
      .in_a  (cur[(2*i)*W +: W]),
      .in_b  (cur[(2*i+1)*W +: W]),
      .out_lo(res_low[(2*i)*W +: W]),
      .out_hi(res_low[(2*i+1)*W +: W])
    );
  end

  // Pairing starting at index 1, ends untouched
  assign res_high[W-1:0]         = cur[W-1:0];
  assign res_high[N*W-1 -: W]    = cur[N*W-1 -: W];
  for (genvar i = 0; i < NHIGH; i++) begin : g_high
    oet_cmp_xchg #(.W(W)) u_cx (
      .in_a  (cur[(2*i+1)*W +: W]),
      .in_b  (cur[(2*i+2)*W +: W]),
      .out_lo(res_high[(2*i+1)*W +: W]),
      .out_hi(res_high[(2*i+2)*W +: W])
    );
  end

  assign nxt = (pairing == PAIR_HIGH) ? res_high : res_low;

endmodule

// File: rtl/oet_ctrl.sv
module oet_ctrl
  import oet_pkg::*;
#(
  parameter int N = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  output logic     load_en,
  output logic     step_en,
  output pairing_e pairing,
  output logic     busy,
  output logic     done
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] phase_cnt;

  assign load_en = start && !busy;
  assign step_en = busy;
  assign pairing = pairing_of(phase_cnt[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      phase_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (load_en) begin
        busy      <= 1'b1;
        phase_cnt <= '0;
      end else if (busy) begin
        phase_cnt <= phase_cnt + 1'b1;
        if (phase_cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/oet_regs.sv
module oet_regs #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_en,
  input  logic           step_en,
  input  logic [N*W-1:0] load_val,
  input  logic [N*W-1:0] step_val,
  output logic [N*W-1:0] q
);

  for (genvar k = 0; k < N; k++) begin : g_elem
    always_ff @(posedge clk) begin
      if (rst)
        q[k*W +: W] <= '0;
      else if (load_en)
        q[k*W +: W] <= load_val[k*W +: W];
      else if (step_en)
        q[k*W +: W] <= step_val[k*W +: W];
    end
  end

endmodule

// File: rtl/oet_sorter.sv
module oet_sorter
  import oet_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N*W-1:0] load_data,
  output logic [N*W-1:0] sorted,
  output logic           busy,
  output logic           done
);

  // R10: size checks at elaboration
  if ((N % 2) != 0 || N < 2) begin : g_bad_n
    $error("oet_sorter: N must be even and at least 2");
  end

  logic           load_en;
  logic           step_en;
  pairing_e       pairing;
  logic [N*W-1:0] arr_q;
  logic [N*W-1:0] arr_nxt;

  oet_ctrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .load_en(load_en),
    .step_en(step_en),
    .pairing(pairing),
    .busy   (busy),
    .done   (done)
  );

  oet_net #(.N(N), .W(W)) u_net (
    .cur    (arr_q),
    .pairing(pairing),
    .nxt    (arr_nxt)
  );

  oet_regs #(.N(N), .W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .step_en (step_en),
    .load_val(load_data),
    .step_val(arr_nxt),
    .q       (arr_q)
  );

  assign sorted = arr_q;

endmodule

// File: rtl/oet_sorter_chk.sv
module oet_sorter_chk #(
  parameter int N = 8,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [N*W-1:0] sorted,
  input logic           busy,
  input logic           done
);

  localparam int CW = $clog2(N + 2);

  logic [CW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  function automatic logic is_ascending(input logic [N*W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < N - 1; k++)
      if (v[k*W +: W] > v[(k+1)*W +: W]) ok = 1'b0;
    return ok;
  endfunction

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_run == CW'(N))); // R5
  AST_RESULT_ORDERED: assert property (@(posedge clk) disable iff (rst)
    done |-> is_ascending(sorted)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(sorted)); // R9

endmodule

bind oet_sorter oet_sorter_chk #(.N(N), .W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .sorted(sorted),
  .busy  (busy),
  .done  (done)
);

// File: tb/oet_sorter_bench.sv
`timescale 1ns/1ps
module oet_sorter_bench;

  localparam int N = 8;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N*W-1:0] load_data = '0;
  logic [N*W-1:0] sorted;
  logic           busy;
  logic           done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  oet_sorter #(.N(N), .W(W)) u_oet_sorter (
    .clk(clk), .rst(rst), .start(start), .load_data(load_data),
    .sorted(sorted), .busy(busy), .done(done)
  );

  // Behavioural reference model
  int m_val[N];
  int m_phase;     // phases remaining
  int m_done_cnt;  // phases done in current run
  bit m_busy, m_done;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_val[k]) m_val[k] = 0;
      m_busy = 0; m_done = 0; m_phase = 0; m_done_cnt = 0;
    end else begin
      m_done = 0;
      if (start && !m_busy) begin
        foreach (m_val[k]) m_val[k] = int'(load_data[k*W +: W]);
        m_busy = 1; m_phase = N; m_done_cnt = 0;
      end else if (m_busy) begin
        int first;
        first = (m_done_cnt % 2 == 0) ? 0 : 1;
        for (int k = first; k + 1 < N; k += 2) begin
          if (m_val[k] > m_val[k+1]) begin
            int t;
            t = m_val[k]; m_val[k] = m_val[k+1]; m_val[k+1] = t;
          end
        end
        m_done_cnt++;
        m_phase--;
        if (m_phase == 0) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  function automatic logic [N*W-1:0] model_vec();
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = W'(m_val[k]);
    return v;
  endfunction

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      string tag;
      tag = m_done ? "R7" : (m_done_cnt % 2 == 1 ? "R3" : "R4");
      checks++;
      if (sorted !== model_vec()) begin
        errors++;
        $display("FAIL %s cycle data: got %h expected %h", tag, sorted, model_vec());
      end
      checks++;
      if (busy !== m_busy || done !== m_done) begin
        errors++;
        $display("FAIL R5/R6 flags: got busy=%0b done=%0b expected busy=%0b done=%0b",
                 busy, done, m_busy, m_done);
      end
    end
  end

  task automatic check_vec(input string req, input logic [N*W-1:0] got,
                           input logic [N*W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [N*W-1:0] pack8(input int a0, a1, a2, a3, a4, a5, a6, a7);
    logic [N*W-1:0] v;
    v = {W'(a7), W'(a6), W'(a5), W'(a4), W'(a3), W'(a2), W'(a1), W'(a0)};
    return v;
  endfunction

  function automatic logic [N*W-1:0] sort_ref(input logic [N*W-1:0] v);
    int a[$];
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) a.push_back(int'(v[k*W +: W]));
    a.sort();
    for (int k = 0; k < N; k++) r[k*W +: W] = W'(a[k]);
    return r;
  endfunction

  // Pulse start with vec, wait for done, check final result
  task automatic run_sort(input logic [N*W-1:0] vec, input string name);
    @(negedge clk);
    start = 1'b1; load_data = vec;
    @(negedge clk);
    start = 1'b0;
    check_vec("R2", sorted, vec);
    while (!done) @(negedge clk);
    check_vec("R7", sorted, sort_ref(vec));
    if (name.len() == 0) $display("empty name");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N*W-1:0] ex;
    logic [N*W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || sorted !== '0) begin
      errors++;
      $display("FAIL R1: got busy=%0b done=%0b data=%h expected 0 0 0", busy, done, sorted);
    end

    // R3 example: first phase result
    ex = pack8(3, 2, 3, 8, 5, 6, 4, 1);
    @(negedge clk);
    start = 1'b1; load_data = ex;
    @(negedge clk);
    start = 1'b0;
    check_vec("R2", sorted, ex);
    @(negedge clk);
    check_vec("R3", sorted, pack8(2, 3, 3, 8, 5, 6, 1, 4));
    @(negedge clk);
    // R4 second phase: ends fixed
    check_vec("R4", sorted, pack8(2, 3, 3, 5, 8, 1, 6, 4));
    while (!done) @(negedge clk);
    check_vec("R7", sorted, pack8(1, 2, 3, 3, 4, 5, 6, 8));
    // R6 done lasts one cycle
    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R6: got done=%0b expected 0", done);
    end
    // R9 hold while idle
    held = sorted;
    repeat (4) @(negedge clk);
    check_vec("R9", sorted, held);

    // Worst case and boundary patterns (R5, R7)
    run_sort(pack8(8, 7, 6, 5, 4, 3, 2, 1), "descending");
    run_sort(pack8(1, 2, 3, 4, 5, 6, 7, 8), "ascending");
    run_sort(pack8(9, 9, 9, 9, 9, 9, 9, 9), "equal");
    run_sort(pack8(255, 0, 128, 127, 255, 1, 0, 200), "extremes");

    // R8 start while busy is ignored
    ex = pack8(40, 30, 20, 10, 90, 80, 70, 60);
    @(negedge clk);
    start = 1'b1; load_data = ex;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; load_data = pack8(1, 1, 1, 1, 1, 1, 1, 1);
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check_vec("R8", sorted, sort_ref(ex));

    // Random patterns
    for (int r = 0; r < 20; r++) begin
      logic [N*W-1:0] rv;
      for (int k = 0; k < N; k++) rv[k*W +: W] = W'($urandom);
      run_sort(rv, "random");
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule